// File: doc/BRIEF.md
# I2C Bus Recovery Sequencer

This block brings a hung two-wire bus back to idle. A device that was interrupted mid-byte can keep holding the data line low and wait for clocks that never come. A single start pulse makes the sequencer leave the data line released and run a fixed train of clock pulses. Those pulses let any such device finish its byte and let go of the line. The sequencer then closes with a full stop condition and releases both lines.

Both lines are open-drain. Each output is an enable: when it is 1 the line is pulled low, and when it is 0 the line is released. All timing is built from a quarter bus period. The parameter `QTR_CYCLES` sets that quarter in system clock cycles, and a prescaler that restarts on every accepted start pulse counts it out. The default of 1000 cycles at 200 MHz gives 5 us per quarter, which is a 50 kHz bus clock.

While it runs, the block samples the data line at the end of the last clock pulse. It reports that level so the caller can see whether the bus was freed.

Top module: `bus_unstick_seq`

## Requirements
- R1: After reset, `scl_oe_o`, `sda_oe_o`, `busy_o`, `done_o` and `sda_free_o` are all 0.
- R2: When `start_i` is 1 and `busy_o` is 0 at a clock edge, `busy_o` is 1 from the next cycle. It stays 1 until the closing quarter of the stop ends.
- R3: The first quarter of a run keeps both lines released (both enables 0) before the clock line is first pulled low.
- R4: The pulse train pulls the clock line low exactly `PULSES` times (default 9), and `sda_oe_o` stays 0 for the whole train.
- R5: Every low phase and every high phase of the train lasts two quarters, which is 2*`QTR_CYCLES` clock cycles.
- R6: After the last pulse, the stop takes four quarters with (`scl_oe_o`,`sda_oe_o`) equal to (1,0), then (1,1), then (0,1), then (0,0). The data line therefore falls only while the clock line is low, and rises only while it is released.
- R7: When the stop ends, `busy_o` falls, `done_o` is 1 for exactly one cycle in that same cycle, and both enables are 0 whenever `busy_o` is 0.
- R8: A `start_i` pulse while `busy_o` is 1 is ignored: the run keeps its timing and ends at the time it would have ended anyway.
- R9: `sda_free_o` takes the level of `sda_i` at the end of the last high phase of the train (1 = data line high). It holds that value until the next run samples again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Request a recovery run |
| sda_i | input | 1 | Sampled level of the data line |
| busy_o | output | 1 | A run is in progress |
| done_o | output | 1 | One-cycle pulse when a run ends |
| scl_oe_o | output | 1 | 1 pulls the clock line low |
| sda_oe_o | output | 1 | 1 pulls the data line low |
| sda_free_o | output | 1 | Data line level seen at the end of the train |

## Verification
The bench builds the sequencer with `QTR_CYCLES` = 3 and `PULSES` = 9. A whole run of 41 quarters then takes 123 cycles, so every cycle of every quarter can be compared with the expected line pattern. A quarter of three cycles also leaves a cycle strictly inside the quarter. That is where a retrigger pulse is placed, and it lets the bench show that retriggering does not stretch the run. The bench runs once with the data line free and once with it stuck low, so both values of `sda_free_o` are observed.

// File: rtl/bus_unstick_seq.sv
module bus_unstick_seq #(
  parameter int QTR_CYCLES = 1000,
  parameter int PULSES     = 9
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic sda_i,
  output logic busy_o,
  output logic done_o,
  output logic scl_oe_o,
  output logic sda_oe_o,
  output logic sda_free_o
);
  localparam int QUARTERS = 4 * PULSES + 5;
  localparam int QW = $clog2(QTR_CYCLES + 1);
  localparam int IW = $clog2(QUARTERS + 1);
  localparam logic [QW-1:0] Q_LAST     = QW'(QTR_CYCLES - 1);
  localparam logic [IW-1:0] TRAIN_LAST = IW'(4 * PULSES);
  localparam logic [IW-1:0] SEQ_LAST   = IW'(QUARTERS - 1);

  logic [QW-1:0] qcnt;
  logic [IW-1:0] qidx;
  logic          tick;
  logic          in_train, in_stop;
  logic [1:0]    ph;
  logic [IW-1:0] sidx;

  assign tick     = (qcnt == Q_LAST);
  assign in_train = busy_o && (qidx != '0) && (qidx <= TRAIN_LAST);
  assign in_stop  = busy_o && (qidx > TRAIN_LAST);
  assign ph       = 2'(qidx - IW'(1));
  assign sidx     = qidx - TRAIN_LAST - IW'(1);

  assign scl_oe_o = (in_train && !ph[1]) || (in_stop && sidx < IW'(2));
  assign sda_oe_o = in_stop && (sidx == IW'(1) || sidx == IW'(2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_o     <= 1'b0;
      done_o     <= 1'b0;
      qcnt       <= '0;
      qidx       <= '0;
      sda_free_o <= 1'b0;
    end else begin
      done_o <= 1'b0;
      if (!busy_o) begin
        if (start_i) begin
          busy_o <= 1'b1;
          qcnt   <= '0;
          qidx   <= '0;
        end
      end else if (tick) begin
        qcnt <= '0;
        if (qidx == TRAIN_LAST) sda_free_o <= sda_i;
        if (qidx == SEQ_LAST) begin
          busy_o <= 1'b0;
          done_o <= 1'b1;
        end else begin
          qidx <= qidx + IW'(1);
        end
      end else begin
        qcnt <= qcnt + QW'(1);
      end
    end
  end
endmodule

// File: rtl/bus_unstick_chk.sv
module bus_unstick_chk #(
  parameter int PULSES = 9
) (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic scl_oe_o,
  input logic sda_oe_o,
  input logic sda_free_o
);
  logic       scl_q;
  logic [7:0] falls;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b0;
      falls <= '0;
    end else begin
      scl_q <= scl_oe_o;
      if (start_i && !busy_o) falls <= '0;
      else if (scl_oe_o && !scl_q) falls <= falls + 8'd1;
    end
  end

  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start_i && !busy_o |=> busy_o); // R2
  AST_PULSE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> falls == 8'(PULSES + 1)); // R4
  AST_SDA_FALL_SCL_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sda_oe_o) |-> scl_oe_o); // R6
  AST_SDA_RISE_SCL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_oe_o) |-> !scl_oe_o); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o); // R7
  AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o); // R7
  AST_IDLE_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o |-> !scl_oe_o && !sda_oe_o); // R7
  AST_FREE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_o && !$past(busy_o) |-> $stable(sda_free_o)); // R9
endmodule

bind bus_unstick_seq bus_unstick_chk #(.PULSES(PULSES)) chk_i (
  .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
  .done_o(done_o), .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o),
  .sda_free_o(sda_free_o));

// File: tb/bus_unstick_seq_tb.sv
module bus_unstick_seq_tb_top;
  localparam int Q = 3;
  localparam int P = 9;
  localparam int NQ = 4 * P + 5;

  // per quarter: bit1 = scl pulled low, bit0 = sda pulled low
  localparam logic [1:0] EXP [NQ] = '{
    2'b00,
    2'b10, 2'b10, 2'b00, 2'b00,  2'b10, 2'b10, 2'b00, 2'b00,
    2'b10, 2'b10, 2'b00, 2'b00,  2'b10, 2'b10, 2'b00, 2'b00,
    2'b10, 2'b10, 2'b00, 2'b00,  2'b10, 2'b10, 2'b00, 2'b00,
    2'b10, 2'b10, 2'b00, 2'b00,  2'b10, 2'b10, 2'b00, 2'b00,
    2'b10, 2'b10, 2'b00, 2'b00,
    2'b10, 2'b11, 2'b01, 2'b00
  };

  logic clk = 1'b0, rst_n = 1'b0, start_i = 1'b0, stuck = 1'b0;
  logic busy_o, done_o, scl_oe_o, sda_oe_o, sda_free_o, sda_i;
  int checks = 0, fails = 0, scl_falls = 0;
  logic scl_prev = 1'b0;

  always #2.5 clk = ~clk;
  assign sda_i = !sda_oe_o && !stuck;

  bus_unstick_seq #(.QTR_CYCLES(Q), .PULSES(P)) dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .sda_i(sda_i),
    .busy_o(busy_o), .done_o(done_o), .scl_oe_o(scl_oe_o),
    .sda_oe_o(sda_oe_o), .sda_free_o(sda_free_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp_v);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp_v, $time);
    end
  endtask

  task automatic run(input bit retrig, input bit exp_free);
    scl_falls = 0;
    @(negedge clk) start_i = 1'b1;
    @(posedge clk);
    @(negedge clk) start_i = 1'b0;
    for (int i = 0; i < NQ; i++) begin
      for (int c = 0; c < Q; c++) begin
        if (!(i == 0 && c == 0)) @(negedge clk);
        chk({scl_oe_o, sda_oe_o} == EXP[i],
            i == 0 ? "R3" : (i <= 4 * P ? "R5" : "R6"),
            {scl_oe_o, sda_oe_o}, EXP[i]);
        chk(busy_o == 1'b1 && done_o == 1'b0, "R2", busy_o, 1);
        if (i >= 1 && i <= 4 * P)
          chk(sda_oe_o == 1'b0, "R4", sda_oe_o, 0);
        if (scl_oe_o && !scl_prev && i <= 4 * P) scl_falls++;
        scl_prev = scl_oe_o;
        if (retrig && i == 10 && c == 1) start_i = 1'b1;
        if (retrig && i == 10 && c == 2) start_i = 1'b0;
        @(posedge clk);
      end
    end
    scl_prev = 1'b0;
    @(negedge clk);
    chk(done_o == 1'b1 && busy_o == 1'b0, retrig ? "R8" : "R7", done_o, 1);
    chk(!scl_oe_o && !sda_oe_o, "R7", {scl_oe_o, sda_oe_o}, 0);
    chk(scl_falls == P, "R4", scl_falls, P);
    chk(sda_free_o == exp_free, "R9", sda_free_o, exp_free);
    @(negedge clk);
    chk(done_o == 1'b0 && busy_o == 1'b0, "R7", done_o, 0);
    repeat (4) @(negedge clk);
    chk(sda_free_o == exp_free && !busy_o, "R9", sda_free_o, exp_free);
  endtask

  initial begin
    #1;
    chk(!scl_oe_o && !sda_oe_o && !busy_o && !done_o && !sda_free_o, "R1",
        {busy_o, done_o, scl_oe_o, sda_oe_o, sda_free_o}, 0);
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;
    @(negedge clk);
    chk(!busy_o && !scl_oe_o && !sda_oe_o, "R1", busy_o, 0);
    stuck = 1'b0; run(1'b0, 1'b1);
    stuck = 1'b1; run(1'b0, 1'b0);
    stuck = 1'b0; run(1'b1, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    #1000000;
    checks++;
    fails++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule